// File: doc/BRIEF.md
# Masked-Write Control Register Bank

This block holds a small bank of 16-bit control registers behind a 32-bit write port. Every write word carries its own per-bit write enable in bits 31:16, lined up bit for bit with the data in bits 15:0. Software can therefore set some control bits and clear others in one write, without reading the register first and without racing another agent that changes other bits of the same register.

A mask bit at 1 lets the register bit take the matching data bit. A mask bit at 0 leaves the register bit as it was. Setting bits S and clearing bits C in one write uses the word `{S | C, S}`. A set-only write is the same word with C empty, and a clear-only write is the same word with S empty.

The bus is a plain register port: a one-cycle write strobe, an address shared by reads and writes, 32-bit write data and 32-bit read data. Register data does not move as a stream, so no valid/ready handshake is present and no back-pressure exists. A write always completes on the clock edge where the strobe is sampled, and read data is available in the same cycle as the address. Each register's stored value is also driven continuously on an output vector for the logic it controls.

Top module: `hwm_ctrl_bank`

## Requirements
- R1: While synchronous active-low reset is asserted at a clock edge, register i loads bits [16i+15:16i] of the parameter RST_VALS.
- R2: On a write, each register bit whose mask bit (write data bit 16+k) is 1 takes the value of write data bit k. A data bit of 1 sets that register bit.
- R3: A register bit whose mask bit is 1 and whose data bit is 0 becomes 0, so a bit named only in the clear pattern is cleared.
- R4: A register bit whose mask bit is 0 keeps its previous value, whatever the matching data bit holds.
- R5: A write whose mask (bits 31:16) is all zero leaves the addressed register unchanged.
- R6: One write of the word {S|C, S} sets every bit of S and clears every bit of C that is not in S, in the same clock edge.
- R7: Read data gives the addressed register's stored value in bits 15:0 and zero in bits 31:16, in the same cycle the address is presented.
- R8: Output vector bits [16i+15:16i] show register i's stored value, updated on the clock edge that samples the write.
- R9: A write changes only the register at its address. A write to an address at or above NUM_REGS changes no register, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | ADDR_W | Register index for both write and read |
| wr_data | input | 32 | Bits 31:16 are the per-bit enable, bits 15:0 are the data |
| rd_data | output | 32 | Zero-extended value of the addressed register |
| ctrl_out | output | 16*NUM_REGS | All stored register values, register i in bits [16i+15:16i] |

## Verification
The bench builds the bank with five registers. The address field is then three bits wide, so indexes 5 to 7 can be driven and show that out-of-range writes and reads have no effect. Each of the five reset values has a different pattern: all ones, all zeros, only the end bits set, and two mixed values. This exposes a register that loads the wrong slice or gets mask handling wrong at the word edges. A reference model then follows a long run of random mixed set/clear writes across all five registers.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  // Apply one masked write word to a stored half-word.
  function automatic logic [HALF_W-1:0] merge_half(
    input logic [HALF_W-1:0] cur,
    input logic [WORD_W-1:0] word
  );
    logic [HALF_W-1:0] en;
    logic [HALF_W-1:0] val;
    en  = word[WORD_W-1:HALF_W];
    val = word[HALF_W-1:0];
    return (cur & ~en) | (val & en);
  endfunction
endpackage

// File: rtl/hwm_addr_decode.sv
module hwm_addr_decode #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_REGS-1:0] hit
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = wr_en && (int'(addr) == i);
  end

  always_comb begin
    assert ($onehot0(hit)) else $error("assert_single_target_R9 failed");
  end
endmodule

// File: rtl/hwm_reg_cell.sv
module hwm_reg_cell
  import hwm_pkg::*;
#(
  parameter logic [HALF_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_word,
  output logic [HALF_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST_VAL;
    else if (wr_hit) q <= merge_half(q, wr_word);
  end

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (q == RST_VAL));

  assert_enabled_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_hit)) |->
      ((q & $past(wr_word[WORD_W-1:HALF_W])) ==
       ($past(wr_word[HALF_W-1:0]) & $past(wr_word[WORD_W-1:HALF_W]))));

  assert_unmasked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_hit)) |->
      (((q ^ $past(q)) & ~$past(wr_word[WORD_W-1:HALF_W])) == '0));

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_hit)) |-> $stable(q));
endmodule

// File: rtl/hwm_read_mux.sv
module hwm_read_mux
  import hwm_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 3
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_REGS*HALF_W-1:0] regs,
  output logic [WORD_W-1:0]          rd_data
);
  logic [HALF_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(addr) == i) sel = regs[i*HALF_W +: HALF_W];
    end
    rd_data = {{(WORD_W-HALF_W){1'b0}}, sel};
  end
endmodule

// File: rtl/hwm_ctrl_bank.sv
module hwm_ctrl_bank
  import hwm_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  parameter logic [NUM_REGS*HALF_W-1:0] RST_VALS = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [WORD_W-1:0]          wr_data,
  output logic [WORD_W-1:0]          rd_data,
  output logic [NUM_REGS*HALF_W-1:0] ctrl_out
);
  localparam int BANK_W = NUM_REGS * HALF_W;

  logic [NUM_REGS-1:0] hit;
  logic [BANK_W-1:0]   bank_q;

  hwm_addr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .hit   (hit)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    hwm_reg_cell #(.RST_VAL(RST_VALS[i*HALF_W +: HALF_W])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (hit[i]),
      .wr_word (wr_data),
      .q       (bank_q[i*HALF_W +: HALF_W])
    );
  end

  hwm_read_mux #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rd (
    .addr    (addr),
    .regs    (bank_q),
    .rd_data (rd_data)
  );

  assign ctrl_out = bank_q;

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[WORD_W-1:HALF_W] == '0);

  assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) >= NUM_REGS) |-> (rd_data == '0));

  assert_oob_write_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && (int'($past(addr)) >= NUM_REGS)) |->
      $stable(bank_q));
endmodule

// File: tb/sim_hwm_ctrl_bank.sv
module sim_hwm_ctrl_bank;
  localparam int N  = 5;
  localparam int AW = 3;
  localparam logic [N*16-1:0] RV = {16'h5A5A, 16'h0000, 16'hFFFF, 16'h8001, 16'h1234};

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [N*16-1:0] ctrl_out;

  int total = 0;
  int bad = 0;
  logic [15:0] model [N];

  always #10 clk = ~clk;

  hwm_ctrl_bank #(.NUM_REGS(N), .RST_VALS(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ctrl_out(ctrl_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] w);
    @(negedge clk);
    wr_en = 1; addr = AW'(a); wr_data = w;
    @(negedge clk);
    wr_en = 0;
    if (a < N) model[a] = (model[a] & ~w[31:16]) | (w[15:0] & w[31:16]);
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin
      rd(i, v);
      check(tag, v, {16'h0, model[i]});
      check(tag, {16'h0, ctrl_out[i*16 +: 16]}, {16'h0, model[i]});
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) model[i] = RV[i*16 +: 16];
    check_all("R1 reset values");
  endtask

  task automatic t_set_only();
    logic [31:0] v;
    wr(3, {16'h00F0, 16'h00F0});
    rd(3, v);
    check("R2 set only", v, 32'h0000_00F0);
    check("R8 output after set", {16'h0, ctrl_out[3*16 +: 16]}, 32'h0000_00F0);
  endtask

  task automatic t_clear_only();
    logic [31:0] v;
    wr(2, {16'h0330, 16'h0000});
    rd(2, v);
    check("R3 clear only", v, 32'h0000_FCCF);
  endtask

  task automatic t_unmasked_hold();
    logic [31:0] v;
    wr(1, {16'h000F, 16'hFFF0});
    rd(1, v);
    check("R4 unmasked bits hold", v, 32'h0000_8000);
  endtask

  task automatic t_zero_mask();
    logic [31:0] v;
    wr(4, {16'h0000, 16'hA5C3});
    rd(4, v);
    check("R5 zero mask no change", v, 32'h0000_5A5A);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    // set 0x0101, clear 0x5050 on reg0 (0x1234)
    wr(0, {16'h0101 | 16'h5050, 16'h0101});
    rd(0, v);
    check("R6 combined set clear", v, 32'h0000_0325);
    check("R7 upper half zero", {16'h0, v[31:16]}, 32'h0);
  endtask

  task automatic t_isolation();
    logic [31:0] v;
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_0000);
    rd(6, v);
    check("R9 out of range read", v, 32'h0);
    wr(2, 32'hFFFF_0000);
    check_all("R9 isolation");
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      logic [15:0] s, c;
      int a;
      s = 16'($urandom);
      c = 16'($urandom);
      a = int'($urandom_range(0, N - 1));
      wr(a, {s | c, s});
    end
    check_all("R2 R3 R4 R6 R7 R8 random");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_only();
    t_clear_only();
    t_unmasked_hold();
    t_zero_mask();
    t_set_clear();
    t_isolation();
    t_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule